// File: doc/BRIEF.md
# Multi-Class Oldest-First Issue Selector

This block sits between the ready queues of an out-of-order core and its execution pipes. Five ready queues feed it: integer, floating-point, branch, memory and miscellaneous. Each queue shows its first few entries in order. Each entry carries a valid bit, a squashed flag and a sequence number, and a smaller sequence number means an older instruction. In every cycle the selector works through a fixed chain of selection rounds. In each round it either discards one squashed head or issues the oldest eligible head across all queues. It respects a global issue width and a separate cap for each class.

The selector reports at once, in the same cycle, how many entries to pop from each queue, so the queues can advance on the next edge. The issued instructions land in numbered slots that are registered for the execute stage. The block also keeps a free-entry count for the issue queue and running totals of issued instructions per class and of discarded squashed heads.

Class codes used on `slot_cls` and as queue indices: integer 0, floating-point 1, branch 2, memory 3, miscellaneous 4. In every flat window bus, queue q entry k sits at index q*VIS+k, and entry 0 is the head.

Top module: `iq_issue_sel`

## Requirements
- R1: At most TOTAL_W (default 4) instructions issue per cycle. Selection ends when that many have issued or when no queue has an eligible entry.
- R2: The integer, floating-point, branch and memory classes each issue at most their own limit per cycle (defaults 2, 1, 1, 2). Once a class reaches its limit, its queue is not considered again in that cycle.
- R3: The miscellaneous class (code 4) has no class limit. Only TOTAL_W bounds it.
- R4: Among the eligible visible heads, the one with the smallest sequence number issues first, and its queue advances by one.
- R5: When sequence numbers are equal, the lower class code wins (integer, then floating-point, branch, memory, miscellaneous).
- R6: An eligible head whose squashed flag is set is popped without issuing. It takes no slot and no class quota. Before each oldest-first choice, the squashed eligible head of the lowest-coded queue is discarded first. A squashed head is eligible only while its class is under its limit and fewer than TOTAL_W have issued.
- R7: The n-th instruction issued in a cycle appears in slot n-1 on the next cycle, with its sequence number and class code. `slot_valid` is a contiguous run from slot 0, and `issue_size` equals the number issued.
- R8: `pop_cnt` for each queue (VIS_W bits at q*PC_W) is valid in the same cycle. It equals the number of entries issued plus discarded from that queue, and it never passes the first invalid visible entry.
- R9: `free_entries` resets to IQ_ENTRIES (default 16). Each cycle it changes by the issued count minus `ins_cnt`. Discarded squashed heads do not change it.
- R10: `stat_issued` keeps one running total per class of instructions issued, and `stat_dropped` keeps the running total of discarded squashed heads. All are zero after reset and wrap modulo 2^CNT_W.
- R11: One cycle performs at most TOTAL_W+MAX_DROP (default 6) removals. When many squashed heads use up rounds, fewer than TOTAL_W may issue even though live entries remain.
- R12: While reset is low, and right after it, `slot_valid` and `issue_size` are zero, `free_entries` equals IQ_ENTRIES and all statistics are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hd_valid | input | NQ*VIS | Valid bit of each visible queue entry |
| hd_squash | input | NQ*VIS | Squashed flag of each visible queue entry |
| hd_seq | input | NQ*VIS*SEQ_W | Sequence number of each visible queue entry |
| ins_cnt | input | ENT_W | Live entries written into the issue queue this cycle |
| pop_cnt | output | NQ*PC_W | Entries each queue must pop this cycle |
| slot_valid | output | TOTAL_W | Registered slot occupancy |
| slot_seq | output | TOTAL_W*SEQ_W | Registered sequence number per slot |
| slot_cls | output | TOTAL_W*3 | Registered class code per slot |
| issue_size | output | SZ_W | Registered count of issued instructions |
| free_entries | output | ENT_W | Free issue-queue entries |
| stat_issued | output | NQ*CNT_W | Running issued total per class |
| stat_dropped | output | CNT_W | Running total of discarded squashed heads |

## Verification
The bench drives the selector with directed queue contents. A mixed-age set across all five classes shows that age alone orders the slots. A deep integer and floating-point backlog shows that class caps stop issue below the global width. A miscellaneous-only flood shows that only the width limits that class. Equal sequence numbers in several queues show the fixed class preference. Squashed heads in front of live ones show discarding without quota use, and a wall of squashed heads shows rounds running out before the width is filled. A long random stream with mixed squashing then compares every pop count, slot, counter and free count against a behavioural queue model on every clock.

// File: rtl/iq_sel_pkg.sv
package iq_sel_pkg;
   localparam int NQ    = 5;
   localparam int CLS_W = 3;

   typedef enum logic [CLS_W-1:0] {
      CLS_INT  = 3'd0,
      CLS_FP   = 3'd1,
      CLS_BR   = 3'd2,
      CLS_MEM  = 3'd3,
      CLS_MISC = 3'd4
   } cls_e;
endpackage

// File: rtl/iq_sel_round.sv
// One selection round: discards one squashed head or issues the oldest head.
module iq_sel_round
   import iq_sel_pkg::*;
#(
   parameter int SEQ_W   = 16,
   parameter int VIS     = 3,
   parameter int TOTAL_W = 4,
   parameter int LIM_INT = 2,
   parameter int LIM_FP  = 1,
   parameter int LIM_BR  = 1,
   parameter int LIM_MEM = 2,
   localparam int PC_W   = $clog2(VIS + 1),
   localparam int SZ_W   = $clog2(TOTAL_W + 1)
)(
   input  logic [NQ-1:0][VIS-1:0]            hd_v,
   input  logic [NQ-1:0][VIS-1:0]            hd_sq,
   input  logic [NQ-1:0][VIS-1:0][SEQ_W-1:0] hd_seq,
   input  logic [NQ-1:0][PC_W-1:0]           cur_i,
   input  logic [NQ-1:0][PC_W-1:0]           ccnt_i,
   input  logic [SZ_W-1:0]                   tot_i,
   output logic [NQ-1:0][PC_W-1:0]           cur_o,
   output logic [NQ-1:0][PC_W-1:0]           ccnt_o,
   output logic [SZ_W-1:0]                   tot_o,
   output logic                              drop_o,
   output logic                              iss_o,
   output logic [SEQ_W-1:0]                  iss_seq_o,
   output cls_e                              iss_cls_o
);
   localparam int LIM_OF [NQ] = '{LIM_INT, LIM_FP, LIM_BR, LIM_MEM, TOTAL_W};

   logic                       room;
   logic [NQ-1:0]              elig;
   logic [NQ-1:0]              sq;
   logic [NQ-1:0][SEQ_W-1:0]   seq;

   assign room = (tot_i < SZ_W'(TOTAL_W));

   for (genvar q = 0; q < NQ; q++) begin : g_q
      logic             has_l;
      logic             sq_l;
      logic [SEQ_W-1:0] seq_l;
      logic             cap_l;

      always_comb begin
         has_l = 1'b0;
         sq_l  = 1'b0;
         seq_l = '0;
         for (int k = 0; k < VIS; k++) begin
            if (cur_i[q] == PC_W'(k)) begin
               has_l = hd_v[q][k];
               sq_l  = hd_sq[q][k];
               seq_l = hd_seq[q][k];
            end
         end
      end

      if (q == int'(CLS_MISC)) begin : g_nolim
         assign cap_l = 1'b1;
      end else begin : g_lim
         assign cap_l = (ccnt_i[q] < PC_W'(LIM_OF[q]));
      end

      assign elig[q] = has_l & cap_l & room;
      assign sq[q]   = sq_l;
      assign seq[q]  = seq_l;
   end

   always_comb begin
      logic             found;
      int               pick;
      logic [SEQ_W-1:0] best;

      cur_o     = cur_i;
      ccnt_o    = ccnt_i;
      tot_o     = tot_i;
      drop_o    = 1'b0;
      iss_o     = 1'b0;
      iss_seq_o = '0;
      iss_cls_o = CLS_INT;
      found     = 1'b0;
      pick      = 0;
      best      = '0;

      for (int q = 0; q < NQ; q++) begin
         if (!found && elig[q] && sq[q]) begin
            found = 1'b1;
            pick  = q;
         end
      end

      if (found) begin
         drop_o      = 1'b1;
         cur_o[pick] = cur_i[pick] + PC_W'(1);
      end else begin
         for (int q = 0; q < NQ; q++) begin
            if (elig[q] && (!found || seq[q] < best)) begin
               found = 1'b1;
               pick  = q;
               best  = seq[q];
            end
         end
         if (found) begin
            iss_o        = 1'b1;
            cur_o[pick]  = cur_i[pick] + PC_W'(1);
            ccnt_o[pick] = ccnt_i[pick] + PC_W'(1);
            tot_o        = tot_i + SZ_W'(1);
            iss_seq_o    = best;
            iss_cls_o    = cls_e'(CLS_W'(pick));
         end
      end
   end
endmodule

// File: rtl/iq_sel_core.sv
// Unrolled chain of selection rounds plus slot assembly.
module iq_sel_core
   import iq_sel_pkg::*;
#(
   parameter int SEQ_W    = 16,
   parameter int VIS      = 3,
   parameter int TOTAL_W  = 4,
   parameter int MAX_DROP = 2,
   parameter int LIM_INT  = 2,
   parameter int LIM_FP   = 1,
   parameter int LIM_BR   = 1,
   parameter int LIM_MEM  = 2,
   localparam int PC_W    = $clog2(VIS + 1),
   localparam int SZ_W    = $clog2(TOTAL_W + 1),
   localparam int ROUNDS  = TOTAL_W + MAX_DROP,
   localparam int DW      = $clog2(ROUNDS + 1)
)(
   input  logic [NQ-1:0][VIS-1:0]            hd_v,
   input  logic [NQ-1:0][VIS-1:0]            hd_sq,
   input  logic [NQ-1:0][VIS-1:0][SEQ_W-1:0] hd_seq,
   output logic [NQ-1:0][PC_W-1:0]           pop,
   output logic [NQ-1:0][PC_W-1:0]           cls_cnt,
   output logic [SZ_W-1:0]                   iss_total,
   output logic [DW-1:0]                     drop_cnt,
   output logic [TOTAL_W-1:0]                sl_v,
   output logic [TOTAL_W-1:0][SEQ_W-1:0]     sl_seq,
   output logic [TOTAL_W-1:0][CLS_W-1:0]     sl_cls
);
   logic [NQ-1:0][PC_W-1:0] cur_c  [ROUNDS+1];
   logic [NQ-1:0][PC_W-1:0] cc_c   [ROUNDS+1];
   logic [SZ_W-1:0]         tot_c  [ROUNDS+1];
   logic [ROUNDS-1:0]       drop_r;
   logic [ROUNDS-1:0]       iss_r;
   logic [SEQ_W-1:0]        seq_r  [ROUNDS];
   cls_e                    cls_r  [ROUNDS];

   assign cur_c[0] = '0;
   assign cc_c[0]  = '0;
   assign tot_c[0] = '0;

   for (genvar r = 0; r < ROUNDS; r++) begin : g_rnd
      iq_sel_round #(
         .SEQ_W(SEQ_W), .VIS(VIS), .TOTAL_W(TOTAL_W),
         .LIM_INT(LIM_INT), .LIM_FP(LIM_FP), .LIM_BR(LIM_BR), .LIM_MEM(LIM_MEM)
      ) u_rnd (
         .hd_v      (hd_v),
         .hd_sq     (hd_sq),
         .hd_seq    (hd_seq),
         .cur_i     (cur_c[r]),
         .ccnt_i    (cc_c[r]),
         .tot_i     (tot_c[r]),
         .cur_o     (cur_c[r+1]),
         .ccnt_o    (cc_c[r+1]),
         .tot_o     (tot_c[r+1]),
         .drop_o    (drop_r[r]),
         .iss_o     (iss_r[r]),
         .iss_seq_o (seq_r[r]),
         .iss_cls_o (cls_r[r])
      );
   end

   assign pop       = cur_c[ROUNDS];
   assign cls_cnt   = cc_c[ROUNDS];
   assign iss_total = tot_c[ROUNDS];

   always_comb begin
      drop_cnt = '0;
      for (int r = 0; r < ROUNDS; r++) begin
         drop_cnt = drop_cnt + DW'(drop_r[r]);
      end
   end

   always_comb begin
      sl_v   = '0;
      sl_seq = '0;
      sl_cls = '0;
      for (int r = 0; r < ROUNDS; r++) begin
         if (iss_r[r]) begin
            for (int s = 0; s < TOTAL_W; s++) begin
               if (tot_c[r] == SZ_W'(s)) begin
                  sl_v[s]   = 1'b1;
                  sl_seq[s] = seq_r[r];
                  sl_cls[s] = cls_r[r];
               end
            end
         end
      end
   end
endmodule

// File: rtl/iq_sel_stats.sv
// Free-entry count and running per-class totals.
module iq_sel_stats
   import iq_sel_pkg::*;
#(
   parameter int PC_W       = 2,
   parameter int SZ_W       = 3,
   parameter int DW         = 3,
   parameter int ENT_W      = 5,
   parameter int IQ_ENTRIES = 16,
   parameter int CNT_W      = 16
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NQ-1:0][PC_W-1:0]   cls_cnt,
   input  logic [DW-1:0]             drop_cnt,
   input  logic [SZ_W-1:0]           iss_total,
   input  logic [ENT_W-1:0]          ins_cnt,
   output logic [NQ-1:0][CNT_W-1:0]  stat_iss,
   output logic [CNT_W-1:0]          stat_drop,
   output logic [ENT_W-1:0]          free_ent
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         free_ent <= ENT_W'(IQ_ENTRIES);
      end else begin
         free_ent <= free_ent - ins_cnt + ENT_W'(iss_total);
      end
   end

   for (genvar q = 0; q < NQ; q++) begin : g_cnt
      always_ff @(posedge clk) begin
         if (!rst_n) stat_iss[q] <= '0;
         else        stat_iss[q] <= stat_iss[q] + CNT_W'(cls_cnt[q]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) stat_drop <= '0;
      else        stat_drop <= stat_drop + CNT_W'(drop_cnt);
   end
endmodule

// File: rtl/iq_sel_slotreg.sv
// Output register stage for the issue slots.
module iq_sel_slotreg
   import iq_sel_pkg::*;
#(
   parameter int SEQ_W   = 16,
   parameter int TOTAL_W = 4,
   parameter int SZ_W    = 3
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [TOTAL_W-1:0]            sl_v,
   input  logic [TOTAL_W-1:0][SEQ_W-1:0] sl_seq,
   input  logic [TOTAL_W-1:0][CLS_W-1:0] sl_cls,
   input  logic [SZ_W-1:0]               iss_total,
   output logic [TOTAL_W-1:0]            q_v,
   output logic [TOTAL_W-1:0][SEQ_W-1:0] q_seq,
   output logic [TOTAL_W-1:0][CLS_W-1:0] q_cls,
   output logic [SZ_W-1:0]               q_size
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_v    <= '0;
         q_seq  <= '0;
         q_cls  <= '0;
         q_size <= '0;
      end else begin
         q_v    <= sl_v;
         q_seq  <= sl_seq;
         q_cls  <= sl_cls;
         q_size <= iss_total;
      end
   end
endmodule

// File: rtl/iq_issue_sel.sv
// Top: oldest-first multi-class issue selector.
module iq_issue_sel
   import iq_sel_pkg::*;
#(
   parameter int SEQ_W      = 16,
   parameter int VIS        = 3,
   parameter int TOTAL_W    = 4,
   parameter int MAX_DROP   = 2,
   parameter int LIM_INT    = 2,
   parameter int LIM_FP     = 1,
   parameter int LIM_BR     = 1,
   parameter int LIM_MEM    = 2,
   parameter int IQ_ENTRIES = 16,
   parameter int CNT_W      = 16,
   localparam int PC_W      = $clog2(VIS + 1),
   localparam int SZ_W      = $clog2(TOTAL_W + 1),
   localparam int ENT_W     = $clog2(IQ_ENTRIES + 1),
   localparam int ROUNDS    = TOTAL_W + MAX_DROP,
   localparam int DW        = $clog2(ROUNDS + 1)
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NQ*VIS-1:0]          hd_valid,
   input  logic [NQ*VIS-1:0]          hd_squash,
   input  logic [NQ*VIS*SEQ_W-1:0]    hd_seq,
   input  logic [ENT_W-1:0]           ins_cnt,
   output logic [NQ*PC_W-1:0]         pop_cnt,
   output logic [TOTAL_W-1:0]         slot_valid,
   output logic [TOTAL_W*SEQ_W-1:0]   slot_seq,
   output logic [TOTAL_W*CLS_W-1:0]   slot_cls,
   output logic [SZ_W-1:0]            issue_size,
   output logic [ENT_W-1:0]           free_entries,
   output logic [NQ*CNT_W-1:0]        stat_issued,
   output logic [CNT_W-1:0]           stat_dropped
);
   if (TOTAL_W < 1 || VIS < 1 || MAX_DROP < 0) begin : g_bad_shape
      $error("iq_issue_sel: TOTAL_W and VIS must be at least 1, MAX_DROP non-negative");
   end
   if (LIM_INT < 1 || LIM_INT > VIS || LIM_FP < 1 || LIM_FP > VIS ||
       LIM_BR < 1 || LIM_BR > VIS || LIM_MEM < 1 || LIM_MEM > VIS) begin : g_bad_lim
      $error("iq_issue_sel: class limits must lie in 1..VIS");
   end
   if (TOTAL_W > IQ_ENTRIES) begin : g_bad_ent
      $error("iq_issue_sel: TOTAL_W must not exceed IQ_ENTRIES");
   end
   if (CNT_W < PC_W || CNT_W < DW) begin : g_bad_cnt
      $error("iq_issue_sel: CNT_W too narrow");
   end

   logic [NQ-1:0][VIS-1:0]            v2;
   logic [NQ-1:0][VIS-1:0]            sq2;
   logic [NQ-1:0][VIS-1:0][SEQ_W-1:0] seq2;
   logic [NQ-1:0][PC_W-1:0]           pop2;
   logic [NQ-1:0][PC_W-1:0]           cls_cnt;
   logic [SZ_W-1:0]                   iss_total;
   logic [DW-1:0]                     drop_cnt;
   logic [TOTAL_W-1:0]                sl_v;
   logic [TOTAL_W-1:0][SEQ_W-1:0]     sl_seq;
   logic [TOTAL_W-1:0][CLS_W-1:0]     sl_cls;
   logic [TOTAL_W-1:0][SEQ_W-1:0]     q_seq;
   logic [TOTAL_W-1:0][CLS_W-1:0]     q_cls;
   logic [NQ-1:0][CNT_W-1:0]          st2;

   assign v2      = hd_valid;
   assign sq2     = hd_squash;
   assign seq2    = hd_seq;
   assign pop_cnt = pop2;

   iq_sel_core #(
      .SEQ_W(SEQ_W), .VIS(VIS), .TOTAL_W(TOTAL_W), .MAX_DROP(MAX_DROP),
      .LIM_INT(LIM_INT), .LIM_FP(LIM_FP), .LIM_BR(LIM_BR), .LIM_MEM(LIM_MEM)
   ) u_core (
      .hd_v      (v2),
      .hd_sq     (sq2),
      .hd_seq    (seq2),
      .pop       (pop2),
      .cls_cnt   (cls_cnt),
      .iss_total (iss_total),
      .drop_cnt  (drop_cnt),
      .sl_v      (sl_v),
      .sl_seq    (sl_seq),
      .sl_cls    (sl_cls)
   );

   iq_sel_slotreg #(
      .SEQ_W(SEQ_W), .TOTAL_W(TOTAL_W), .SZ_W(SZ_W)
   ) u_slots (
      .clk       (clk),
      .rst_n     (rst_n),
      .sl_v      (sl_v),
      .sl_seq    (sl_seq),
      .sl_cls    (sl_cls),
      .iss_total (iss_total),
      .q_v       (slot_valid),
      .q_seq     (q_seq),
      .q_cls     (q_cls),
      .q_size    (issue_size)
   );

   assign slot_seq = q_seq;
   assign slot_cls = q_cls;

   iq_sel_stats #(
      .PC_W(PC_W), .SZ_W(SZ_W), .DW(DW), .ENT_W(ENT_W),
      .IQ_ENTRIES(IQ_ENTRIES), .CNT_W(CNT_W)
   ) u_stats (
      .clk       (clk),
      .rst_n     (rst_n),
      .cls_cnt   (cls_cnt),
      .drop_cnt  (drop_cnt),
      .iss_total (iss_total),
      .ins_cnt   (ins_cnt),
      .stat_iss  (st2),
      .stat_drop (stat_dropped),
      .free_ent  (free_entries)
   );

   assign stat_issued = st2;
endmodule

// File: rtl/iq_issue_sel_chk.sv
// Property checker, bound to the selector top.
module iq_issue_sel_chk
   import iq_sel_pkg::*;
#(
   parameter int VIS        = 3,
   parameter int TOTAL_W    = 4,
   parameter int MAX_DROP   = 2,
   parameter int LIM_INT    = 2,
   parameter int LIM_FP     = 1,
   parameter int LIM_BR     = 1,
   parameter int LIM_MEM    = 2,
   parameter int IQ_ENTRIES = 16,
   parameter int CNT_W      = 16,
   localparam int PC_W      = $clog2(VIS + 1),
   localparam int SZ_W      = $clog2(TOTAL_W + 1),
   localparam int ENT_W     = $clog2(IQ_ENTRIES + 1),
   localparam int ROUNDS    = TOTAL_W + MAX_DROP
)(
   input logic                 clk,
   input logic                 rst_n,
   input logic [NQ*VIS-1:0]    hd_valid,
   input logic [ENT_W-1:0]     ins_cnt,
   input logic [NQ*PC_W-1:0]   pop_cnt,
   input logic [TOTAL_W-1:0]   slot_valid,
   input logic [SZ_W-1:0]      issue_size,
   input logic [ENT_W-1:0]     free_entries,
   input logic [NQ*CNT_W-1:0]  stat_issued,
   input logic [CNT_W-1:0]     stat_dropped
);
   localparam int LIM_OF [NQ] = '{LIM_INT, LIM_FP, LIM_BR, LIM_MEM, TOTAL_W};

   logic [NQ*CNT_W-1:0] prev_stat;
   logic                prev_ok;
   logic [CNT_W-1:0]    dsum;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_ok   <= 1'b0;
         prev_stat <= '0;
      end else begin
         prev_ok   <= 1'b1;
         prev_stat <= stat_issued;
      end
   end

   always_comb begin
      dsum = '0;
      for (int q = 0; q < NQ; q++) begin
         dsum = dsum + (stat_issued[q*CNT_W +: CNT_W] - prev_stat[q*CNT_W +: CNT_W]);
      end
   end

   // R1: never more than the global width in one cycle
   p_size_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      issue_size <= SZ_W'(TOTAL_W));

   // R7: occupied slots form a run from slot 0 matching the size
   for (genvar s = 0; s < TOTAL_W; s++) begin : g_slot
      p_slot_pack_r7: assert property (@(posedge clk) disable iff (!rst_n)
         slot_valid[s] == (issue_size > SZ_W'(s)));
   end

   for (genvar q = 0; q < NQ; q++) begin : g_q
      // R8: an empty queue is never popped
      p_pop_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !hd_valid[q*VIS] |-> (pop_cnt[q*PC_W +: PC_W] == '0));
      if (q == int'(CLS_MISC)) begin : g_misc
         // R3: misc bounded only by the global width
         p_misc_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (CNT_W'(stat_issued[q*CNT_W +: CNT_W]
                              - $past(stat_issued[q*CNT_W +: CNT_W])) <= CNT_W'(TOTAL_W)));
      end else begin : g_capped
         // R2: per-class cap
         p_cls_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (CNT_W'(stat_issued[q*CNT_W +: CNT_W]
                              - $past(stat_issued[q*CNT_W +: CNT_W])) <= CNT_W'(LIM_OF[q])));
      end
   end

   // R9: free count bounded and stepping by issued minus inserted
   p_free_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      free_entries <= ENT_W'(IQ_ENTRIES));
   p_free_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (free_entries ==
         ENT_W'($past(free_entries) - $past(ins_cnt) + ENT_W'(issue_size))));

   // R10: class totals advance by exactly the issued count
   p_stat_sum_r10: assert property (@(posedge clk) disable iff (!rst_n)
      prev_ok |-> (dsum == CNT_W'(issue_size)));

   // R11: removals per cycle bounded by the round count
   p_round_cap_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (CNT_W'(stat_dropped - $past(stat_dropped)) + CNT_W'(issue_size)
                        <= CNT_W'(ROUNDS)));
endmodule

bind iq_issue_sel iq_issue_sel_chk #(
   .VIS(VIS), .TOTAL_W(TOTAL_W), .MAX_DROP(MAX_DROP),
   .LIM_INT(LIM_INT), .LIM_FP(LIM_FP), .LIM_BR(LIM_BR), .LIM_MEM(LIM_MEM),
   .IQ_ENTRIES(IQ_ENTRIES), .CNT_W(CNT_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .hd_valid     (hd_valid),
   .ins_cnt      (ins_cnt),
   .pop_cnt      (pop_cnt),
   .slot_valid   (slot_valid),
   .issue_size   (issue_size),
   .free_entries (free_entries),
   .stat_issued  (stat_issued),
   .stat_dropped (stat_dropped)
);

// File: tb/iq_issue_sel_test.sv
module iq_issue_sel_test;
   localparam int CLK_PERIOD = 10;
   localparam int NQ    = 5;
   localparam int SEQ_W = 16;
   localparam int VIS   = 3;
   localparam int TW    = 4;
   localparam int MD    = 2;
   localparam int ENTS  = 16;
   localparam int CW    = 16;
   localparam int PC_W  = 2;
   localparam int SZ_W  = 3;
   localparam int ENT_W = 5;
   localparam int DEPTH = 32;
   localparam int LIMS [NQ] = '{2, 1, 1, 2, 99};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NQ*VIS-1:0]       hd_valid = '0;
   logic [NQ*VIS-1:0]       hd_squash = '0;
   logic [NQ*VIS*SEQ_W-1:0] hd_seq = '0;
   logic [ENT_W-1:0]        ins_cnt = '0;
   logic [NQ*PC_W-1:0]      pop_cnt;
   logic [TW-1:0]           slot_valid;
   logic [TW*SEQ_W-1:0]     slot_seq;
   logic [TW*3-1:0]         slot_cls;
   logic [SZ_W-1:0]         issue_size;
   logic [ENT_W-1:0]        free_entries;
   logic [NQ*CW-1:0]        stat_issued;
   logic [CW-1:0]           stat_dropped;

   iq_issue_sel #(
      .SEQ_W(SEQ_W), .VIS(VIS), .TOTAL_W(TW), .MAX_DROP(MD),
      .LIM_INT(2), .LIM_FP(1), .LIM_BR(1), .LIM_MEM(2),
      .IQ_ENTRIES(ENTS), .CNT_W(CW)
   ) uut (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 0;
   string cur_tag = "R1";

   // behavioural queues
   int qseq [NQ][DEPTH];
   bit qsq  [NQ][DEPTH];
   int qcnt [NQ];
   int pending_ins = 0;

   // expected state
   int exp_size = 0;
   int exp_sseq [TW];
   int exp_scls [TW];
   int exp_free = ENTS;
   int exp_stat [NQ];
   int exp_drop = 0;

   task automatic chk(string tag, string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic push(int q, int seq, bit sq);
      if (qcnt[q] < DEPTH) begin
         qseq[q][qcnt[q]] = seq;
         qsq[q][qcnt[q]]  = sq;
         qcnt[q]++;
         if (!sq) pending_ins++;
      end
   endtask

   task automatic check_regs();
      chk(cur_tag, "issue_size", int'(issue_size), exp_size);
      for (int s = 0; s < TW; s++) begin
         chk(cur_tag, $sformatf("slot%0d valid", s), int'(slot_valid[s]), int'(s < exp_size));
         if (s < exp_size) begin
            chk(cur_tag, $sformatf("slot%0d seq", s), int'(slot_seq[s*SEQ_W +: SEQ_W]), exp_sseq[s]);
            chk(cur_tag, $sformatf("slot%0d cls", s), int'(slot_cls[s*3 +: 3]), exp_scls[s]);
         end
      end
      chk("R9", "free_entries", int'(free_entries), exp_free);
      for (int q = 0; q < NQ; q++)
         chk("R10", $sformatf("stat q%0d", q), int'(stat_issued[q*CW +: CW]), exp_stat[q]);
      chk("R10", "stat_dropped", int'(stat_dropped), exp_drop);
   endtask

   // one full cycle: drive window, model selection, check pops, then registers
   task automatic do_cycle();
      logic [NQ*VIS-1:0]       v;
      logic [NQ*VIS-1:0]       s;
      logic [NQ*VIS*SEQ_W-1:0] sv;
      int cur [NQ];
      int cc [NQ];
      int tot;
      int drops;
      v = '0; s = '0; sv = '0;
      for (int q = 0; q < NQ; q++) begin
         for (int k = 0; k < VIS; k++) begin
            if (k < qcnt[q]) begin
               v[q*VIS+k] = 1'b1;
               s[q*VIS+k] = qsq[q][k];
               sv[(q*VIS+k)*SEQ_W +: SEQ_W] = qseq[q][k][SEQ_W-1:0];
            end
         end
         cur[q] = 0;
         cc[q] = 0;
      end
      hd_valid = v; hd_squash = s; hd_seq = sv;
      ins_cnt = ENT_W'(pending_ins);
      tot = 0; drops = 0;
      for (int r = 0; r < TW + MD; r++) begin
         int pick;
         int best;
         pick = -1;
         for (int q = 0; q < NQ; q++) begin
            if (pick < 0 && cur[q] < VIS && cur[q] < qcnt[q] && cc[q] < LIMS[q]
                && tot < TW && qsq[q][cur[q]]) pick = q;
         end
         if (pick >= 0) begin
            cur[pick]++;
            drops++;
         end else begin
            best = 0;
            for (int q = 0; q < NQ; q++) begin
               if (cur[q] < VIS && cur[q] < qcnt[q] && cc[q] < LIMS[q] && tot < TW
                   && (pick < 0 || qseq[q][cur[q]] < best)) begin
                  pick = q;
                  best = qseq[q][cur[q]];
               end
            end
            if (pick >= 0) begin
               exp_sseq[tot] = best;
               exp_scls[tot] = pick;
               cur[pick]++;
               cc[pick]++;
               tot++;
            end
         end
      end
      #1;
      for (int q = 0; q < NQ; q++)
         chk("R8", $sformatf("pop q%0d", q), int'(pop_cnt[q*PC_W +: PC_W]), cur[q]);
      exp_size = tot;
      exp_free = exp_free - pending_ins + tot;
      exp_drop = exp_drop + drops;
      for (int q = 0; q < NQ; q++) begin
         exp_stat[q] += cc[q];
         for (int k = 0; k + cur[q] < qcnt[q]; k++) begin
            qseq[q][k] = qseq[q][k + cur[q]];
            qsq[q][k]  = qsq[q][k + cur[q]];
         end
         qcnt[q] -= cur[q];
      end
      pending_ins = 0;
      @(negedge clk);
      #1;
      check_regs();
   endtask

   task automatic drain();
      for (int i = 0; i < 40; i++) begin
         if (qcnt[0] + qcnt[1] + qcnt[2] + qcnt[3] + qcnt[4] == 0) break;
         do_cycle();
      end
      do_cycle();
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   initial begin
      for (int q = 0; q < NQ; q++) begin
         qcnt[q] = 0;
         exp_stat[q] = 0;
      end
      repeat (3) @(negedge clk);
      #1;
      // R12: reset state while reset is held
      chk("R12", "size in reset", int'(issue_size), 0);
      chk("R12", "free in reset", int'(free_entries), ENTS);
      rst_n = 1'b1;
      #1;
      chk("R12", "slots after reset", int'(slot_valid), 0);
      chk("R12", "dropped after reset", int'(stat_dropped), 0);
      chk("R12", "int stat after reset", int'(stat_issued[0 +: CW]), 0);

      // R4: mixed ages across all classes
      cur_tag = "R4";
      push(0, 5, 0); push(1, 3, 0); push(2, 4, 0); push(3, 1, 0); push(4, 9, 0);
      do_cycle();
      chk("R4", "oldest in slot0", int'(slot_seq[0 +: SEQ_W]), 1);
      drain();

      // R2: class caps stop issue below the width
      cur_tag = "R2";
      push(0, 1, 0); push(0, 2, 0); push(0, 3, 0); push(1, 4, 0); push(1, 5, 0);
      do_cycle();
      chk("R2", "capped size", int'(issue_size), 3);
      drain();

      // R3: misc flood bounded only by width
      cur_tag = "R3";
      push(4, 1, 0); push(4, 2, 0); push(4, 3, 0); push(0, 4, 0); push(0, 5, 0);
      do_cycle();
      chk("R3", "misc count", int'(stat_issued[4*CW +: CW]) - exp_stat[4] + 3, 3);
      chk("R1", "full width", int'(issue_size), TW);
      drain();

      // R5: equal ages resolved by class code
      cur_tag = "R5";
      push(4, 7, 0); push(1, 7, 0); push(0, 7, 0);
      do_cycle();
      chk("R5", "tie slot0 cls", int'(slot_cls[0 +: 3]), 0);
      chk("R5", "tie slot2 cls", int'(slot_cls[6 +: 3]), 4);
      drain();

      // R6: squashed head discarded without quota
      cur_tag = "R6";
      push(0, 1, 1); push(0, 2, 0); push(0, 6, 0); push(1, 3, 0);
      do_cycle();
      chk("R6", "size with drop", int'(issue_size), 3);
      drain();

      // R11: wall of squashed heads exhausts rounds
      cur_tag = "R11";
      push(0, 1, 1); push(0, 10, 0); push(0, 11, 0);
      push(1, 2, 1); push(2, 3, 1); push(3, 4, 1);
      push(4, 5, 0); push(4, 6, 0);
      do_cycle();
      chk("R11", "size after drops", int'(issue_size), 2);
      drain();

      // random stream
      cur_tag = "R1";
      begin
         int gseq = 100;
         int live = 0;
         for (int c = 0; c < 400; c++) begin
            live = ENTS - exp_free;
            for (int q = 0; q < NQ; q++) begin
               if ($urandom_range(0, 2) != 0) begin
                  bit sq;
                  sq = ($urandom_range(0, 5) == 0);
                  if (sq || live + pending_ins < ENTS) push(q, gseq, sq);
                  gseq++;
               end
            end
            do_cycle();
         end
         drain();
      end

      finished = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end
endmodule